// File: doc/BRIEF.md
# Pipelined Byte-Lane Synchronous SRAM Core

This block is a single-port synchronous static memory. Each word holds `LANES` byte lanes. Each lane is 9 bits wide: 8 data bits and one parity bit. Every control and data input is registered on the rising clock edge.

Writes complete on the edge that samples them. Reads pass through an output register, so read data appears in the cycle after the address edge. A separate enable tells the pad ring when to drive the shared data bus.

The block sits behind an external burst sequencer. That sequencer supplies the address for every beat, a select flag, and a flag that marks a cycle opened by the processor address strobe.

A global write pulls every lane into a write. Per-lane write strobes, qualified by a byte-write enable, pick individual lanes instead. An asynchronous output enable gates the drivers. A sleep input parks the core after a two-edge entry delay and keeps the array contents while it sleeps.

The data path is a fixed-timing pin interface, not a stream. There is no ready signal and no back-pressure: every selected cycle is accepted on its edge. A caller that cannot take read data must deselect the core or hold the output enable high.

Top module: `sram_pbw_core`

## Requirements
- R1: An awake, selected edge is a write when `pstart_i` is low and either `gwr_n_i` is low, or `bwe_n_i` is low with at least one bit of `lane_wr_n_i` low. Every other awake, selected edge is a read. In particular, `bwe_n_i` low with all lane strobes high is a read, and so is `bwe_n_i` high with some lane strobes low.
- R2: `gwr_n_i` low writes all lanes, whatever the values of `bwe_n_i` and `lane_wr_n_i`.
- R3: With `gwr_n_i` high and `bwe_n_i` low, lane k (bits [9k+8:9k] of the data word, where bit 9k+8 is that lane's parity bit) is written only when `lane_wr_n_i[k]` is low. All other lanes keep their contents.
- R4: An edge with `pstart_i` high is always a read, and the write controls on that edge are ignored. The following edge decodes its own write controls normally, which is how the second beat of a burst becomes a write.
- R5: After a read edge, `rdata_o` holds the addressed word during the next cycle. In that cycle `drive_o` is high while `oe_n_i` is low.
- R6: After a deselected edge (`sel_i` low) or a write edge, `drive_o` is low for the next cycle, whatever the value of `oe_n_i`.
- R7: While reset is asserted and after it is released, `drive_o` is low until a read edge occurs.
- R8: `oe_n_i` high forces `drive_o` low at once, with no clock edge needed. `oe_n_i` low re-enables the drivers in the same way.
- R9: Once `sleep_i` has been high at two consecutive edges, later edges ignore all other inputs and `drive_o` is low.
- R10: After `sleep_i` falls, the first two edges at which it is sampled low are still ignored. The third such edge is decoded normally.
- R11: Array contents survive sleep, including any write attempted while asleep.
- R12: A read on the edge right after a write to the same address returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control state |
| addr_i | input | ADDR_W | Word address for this beat |
| sel_i | input | 1 | Core selected this edge |
| pstart_i | input | 1 | Beat opened by the processor strobe, forces a read |
| gwr_n_i | input | 1 | Global write, active low |
| bwe_n_i | input | 1 | Byte-write qualifier, active low |
| lane_wr_n_i | input | LANES | Per-lane write strobes, active low |
| wdata_i | input | 9*LANES | Write word, lane k at [9k+8:9k] |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep request |
| rdata_o | output | 9*LANES | Registered read word |
| drive_o | output | 1 | Tri-state driver enable for the data bus |

## Verification
The bench sets up four kinds of contradictory write controls:
- a global write carrying junk lane strobes;
- a byte-write enable with no lane strobe low;
- lane strobes with the byte-write enable high;
- a processor-strobe beat with a global write.

A decoder that gets any priority wrong corrupts a word that is read back later. A lane merge that leaves out the parity bit shows up as a wrong bit 8 or bit 26.

Three timing cases are checked:
- Drivers that stay on after a deselect or a write show up as a drive enable in the cycle after.
- A sleep counter that is off by one edge, on entry or on exit, either drives data during the guard edges or drops a legitimate read.
- A write that lands while asleep changes the retained word.

// File: rtl/sram_pbw_pkg.sv
package sram_pbw_pkg;
  localparam int LANE_W = 9;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sram_op_e;
endpackage

// File: rtl/sram_pbw_sleep.sv
module sram_pbw_sleep #(
  parameter int GUARD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_i,
  output logic asleep_o
);
  logic [GUARD-1:0] hist_q;

  generate
    if (GUARD == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= sleep_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[GUARD-2:0], sleep_i};
      end
    end
  endgenerate

  // Asleep once the request has crossed GUARD edges; wakes GUARD edges after release.
  assign asleep_o = hist_q[GUARD-1];
endmodule

// File: rtl/sram_pbw_decode.sv
module sram_pbw_decode
  import sram_pbw_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             asleep_i,
  input  logic             sel_i,
  input  logic             pstart_i,
  input  logic             gwr_n_i,
  input  logic             bwe_n_i,
  input  logic [LANES-1:0] lane_wr_n_i,
  output sram_op_e         op_o,
  output logic [LANES-1:0] lane_en_o
);
  logic any_lane;
  logic wr_req;

  assign any_lane = ~&lane_wr_n_i;
  assign wr_req   = ~gwr_n_i | (~bwe_n_i & any_lane);

  always_comb begin
    op_o      = OP_IDLE;
    lane_en_o = '0;
    if (!asleep_i && sel_i) begin
      if (!pstart_i && wr_req) begin
        op_o      = OP_WRITE;
        lane_en_o = gwr_n_i ? ~lane_wr_n_i : '1;
      end else begin
        op_o = OP_READ;
      end
    end
  end
endmodule

// File: rtl/sram_pbw_array.sv
module sram_pbw_array
  import sram_pbw_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int ADDR_W = 6
) (
  input  logic                      clk,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [LANES-1:0]          we_i,
  input  logic                      re_i,
  input  logic [LANES*LANE_W-1:0]   wdata_i,
  output logic [LANES*LANE_W-1:0]   rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  genvar k;
  generate
    for (k = 0; k < LANES; k++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      logic [LANE_W-1:0] rd_q;

      always_ff @(posedge clk) begin
        if (we_i[k]) mem[addr_i] <= wdata_i[k*LANE_W +: LANE_W];
        if (re_i)    rd_q        <= mem[addr_i];
      end

      assign rdata_o[k*LANE_W +: LANE_W] = rd_q;
    end
  endgenerate
endmodule

// File: rtl/sram_pbw_core.sv
module sram_pbw_core
  import sram_pbw_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int ADDR_W      = 6,
  parameter int SLEEP_GUARD = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    sel_i,
  input  logic                    pstart_i,
  input  logic                    gwr_n_i,
  input  logic                    bwe_n_i,
  input  logic [LANES-1:0]        lane_wr_n_i,
  input  logic [LANES*9-1:0]      wdata_i,
  input  logic                    oe_n_i,
  input  logic                    sleep_i,
  output logic [LANES*9-1:0]      rdata_o,
  output logic                    drive_o
);
  localparam int WORD_W = LANES * LANE_W;

  logic             asleep;
  sram_op_e         op;
  logic [LANES-1:0] lane_en;
  logic             rd_valid_q;
  logic [WORD_W-1:0] rd_word;

  sram_pbw_sleep #(.GUARD(SLEEP_GUARD)) u_sleep (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep_i  (sleep_i),
    .asleep_o (asleep)
  );

  sram_pbw_decode #(.LANES(LANES)) u_dec (
    .asleep_i    (asleep),
    .sel_i       (sel_i),
    .pstart_i    (pstart_i),
    .gwr_n_i     (gwr_n_i),
    .bwe_n_i     (bwe_n_i),
    .lane_wr_n_i (lane_wr_n_i),
    .op_o        (op),
    .lane_en_o   (lane_en)
  );

  sram_pbw_array #(.LANES(LANES), .ADDR_W(ADDR_W)) u_arr (
    .clk     (clk),
    .addr_i  (addr_i),
    .we_i    (lane_en),
    .re_i    (op == OP_READ),
    .wdata_i (wdata_i),
    .rdata_o (rd_word)
  );

  // Output stage: valid only in the cycle after a read edge (single-cycle deselect).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid_q <= 1'b0;
    else        rd_valid_q <= (op == OP_READ);
  end

  assign rdata_o = rd_word;
  assign drive_o = rd_valid_q & ~oe_n_i & ~asleep;
endmodule

// File: rtl/sram_pbw_chk.sv
module sram_pbw_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_i,
  input logic             pstart_i,
  input logic             gwr_n_i,
  input logic             bwe_n_i,
  input logic [LANES-1:0] lane_wr_n_i,
  input logic             oe_n_i,
  input logic             sleep_i,
  input logic             asleep,
  input logic             drive_o
);
  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R6: deselect edge leaves the bus floating next cycle
  a_r6_deselect_float: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> !drive_o);

  // R1 / R6: any decoded write edge turns the drivers off next cycle
  a_r1_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && !asleep && !pstart_i && (!gwr_n_i || (!bwe_n_i && !(&lane_wr_n_i))))
      |=> !drive_o);

  // R4 / R5: a processor-strobe beat is a read and drives next cycle when enabled
  a_r4_pstart_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && pstart_i && !asleep) |=> (drive_o == (!oe_n_i && !asleep)));

  // R8: output enable high keeps the drivers off
  a_r8_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n_i |-> !drive_o);

  // R9: sleep seen two edges back means the bus floats
  a_r9_sleep_float: assert property (@(posedge clk) disable iff (!rst_n || age_q != 2'd3)
    $past(sleep_i, 2) |-> !drive_o);
endmodule

bind sram_pbw_core sram_pbw_chk #(.LANES(LANES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sel_i       (sel_i),
  .pstart_i    (pstart_i),
  .gwr_n_i     (gwr_n_i),
  .bwe_n_i     (bwe_n_i),
  .lane_wr_n_i (lane_wr_n_i),
  .oe_n_i      (oe_n_i),
  .sleep_i     (sleep_i),
  .asleep      (asleep),
  .drive_o     (drive_o)
);

// File: tb/sim_sram_pbw_core.sv
`timescale 1ns/100ps
module sim_sram_pbw_core;
  localparam int LANES = 4;
  localparam int LW    = 9;
  localparam int W     = LANES * LW;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n = 1'b0;
  logic [AW-1:0]    addr_i = '0;
  logic             sel_i = 1'b0, pstart_i = 1'b0, gwr_n_i = 1'b1, bwe_n_i = 1'b1;
  logic [LANES-1:0] lane_wr_n_i = '1;
  logic [W-1:0]     wdata_i = '0;
  logic             oe_n_i = 1'b0, sleep_i = 1'b0;
  logic [W-1:0]     rdata_o;
  logic             drive_o;

  sram_pbw_core u0 (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .sel_i(sel_i), .pstart_i(pstart_i),
    .gwr_n_i(gwr_n_i), .bwe_n_i(bwe_n_i), .lane_wr_n_i(lane_wr_n_i), .wdata_i(wdata_i),
    .oe_n_i(oe_n_i), .sleep_i(sleep_i), .rdata_o(rdata_o), .drive_o(drive_o)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R7";
  bit    run_cmp = 1'b0;
  bit    done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] fill(input int a);
    return 36'h5_A5A5_A5A5 ^ (36'(a) * 36'h0_0102_0409);
  endfunction

  // Behavioural reference: word store, a two-entry sleep history and one pending read.
  logic [W-1:0] mmem [DEPTH];
  bit           mvld = 1'b0;
  logic [W-1:0] mdat = '0;
  bit           h0 = 1'b0, h1 = 1'b0;

  always @(posedge clk) begin
    automatic bit asl;
    automatic bit wr;
    if (!rst_n) begin
      mvld = 1'b0; h0 = 1'b0; h1 = 1'b0;
    end else begin
      asl = h1;
      h1 = h0;
      h0 = sleep_i;
      mvld = 1'b0;
      if (!asl && sel_i) begin
        wr = !pstart_i && (!gwr_n_i || (!bwe_n_i && lane_wr_n_i != '1));
        if (wr) begin
          for (int k = 0; k < LANES; k++)
            if (!gwr_n_i || !lane_wr_n_i[k]) mmem[addr_i][k*LW +: LW] = wdata_i[k*LW +: LW];
        end else begin
          mvld = 1'b1;
          mdat = mmem[addr_i];
        end
      end
    end
  end

  always @(negedge clk) begin
    automatic bit exp_drv;
    if (rst_n && run_cmp && !done) begin
      exp_drv = mvld && !oe_n_i && !h1;
      chk(drive_o == exp_drv, {cur_req, " drive"}, W'(drive_o), W'(exp_drv));
      if (exp_drv) chk(rdata_o == mdat, {cur_req, " data"}, rdata_o, mdat);
    end
  end

  task automatic op(input bit s, input bit p, input bit gw, input bit bw,
                    input logic [LANES-1:0] ln, input logic [AW-1:0] a, input logic [W-1:0] d);
    sel_i = s; pstart_i = p; gwr_n_i = gw; bwe_n_i = bw; lane_wr_n_i = ln; addr_i = a; wdata_i = d;
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    op(1'b1, 1'b0, 1'b1, 1'b1, '1, a, '0);
  endtask

  task automatic idle();
    op(1'b0, 1'b0, 1'b1, 1'b1, '1, '0, '0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(drive_o == 1'b0, "R7 in reset", W'(drive_o), '0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(drive_o == 1'b0, "R7 after reset", W'(drive_o), '0);
    run_cmp = 1'b1;

    // R2: global write with junk lane strobes and byte-write enable
    cur_req = "R2";
    for (int a = 0; a < DEPTH; a++)
      op(1'b1, 1'b0, 1'b0, a[0], LANES'(a), AW'(a), fill(a));
    rd(9);
    chk(rdata_o == fill(9), "R2", rdata_o, fill(9));

    // R3: lanes 0 and 2 written, parity bits 8 and 26 included
    cur_req = "R3";
    op(1'b1, 1'b0, 1'b1, 1'b0, 4'b1010, 6'd5, '1);
    rd(5);
    chk(rdata_o == (fill(5) | 36'h0_07FC_01FF), "R3", rdata_o, fill(5) | 36'h0_07FC_01FF);

    // R1: byte-write enable without lanes, and lanes without enable, are reads
    cur_req = "R1";
    op(1'b1, 1'b0, 1'b1, 1'b0, 4'hF, 6'd7, '1);
    chk(drive_o == 1'b1, "R1 bwe only is read", W'(drive_o), 1);
    op(1'b1, 1'b0, 1'b1, 1'b1, 4'h0, 6'd7, '1);
    rd(7);
    chk(rdata_o == fill(7), "R1 no write", rdata_o, fill(7));

    // R4: processor-strobe beat reads; next beat writes
    cur_req = "R4";
    op(1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 6'd12, '0);
    chk(drive_o && rdata_o == fill(12), "R4 strobe read", rdata_o, fill(12));
    op(1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 6'd12, 36'h0_0000_1234);

    // R12: read right after the write
    cur_req = "R12";
    rd(12);
    chk(rdata_o == 36'h0_0000_1234, "R12", rdata_o, 36'h0_0000_1234);
    op(1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 6'd20, 36'h9_8765_4321);
    rd(20);
    chk(rdata_o == 36'h9_8765_4321, "R12 second", rdata_o, 36'h9_8765_4321);

    // R5 / R6: read then deselect, read then write
    cur_req = "R6";
    rd(3);
    chk(drive_o == 1'b1, "R5 read drives", W'(drive_o), 1);
    idle();
    chk(drive_o == 1'b0, "R6 deselect floats", W'(drive_o), '0);
    rd(3);
    op(1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 6'd30, fill(30));
    chk(drive_o == 1'b0, "R6 write floats", W'(drive_o), '0);

    // R8: asynchronous enable
    cur_req = "R8";
    rd(3);
    oe_n_i = 1'b1; #0.5;
    chk(drive_o == 1'b0, "R8 oe off", W'(drive_o), '0);
    oe_n_i = 1'b0; #0.5;
    chk(drive_o == 1'b1, "R8 oe on", W'(drive_o), 1);

    // R9: entry guard, then writes ignored while asleep
    cur_req = "R9";
    sleep_i = 1'b1;
    rd(2);
    rd(2);
    chk(drive_o == 1'b0, "R9 asleep floats", W'(drive_o), '0);
    op(1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 6'd2, '0);
    op(1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 6'd2, '0);
    rd(2);

    // R10: two ignored edges after release
    cur_req = "R10";
    sleep_i = 1'b0;
    rd(2);
    rd(2);
    chk(drive_o == 1'b0, "R10 exit guard", W'(drive_o), '0);

    // R11: contents retained
    cur_req = "R11";
    rd(2);
    chk(drive_o && rdata_o == fill(2), "R11 retained", rdata_o, fill(2));
    idle();
    idle();
    finish_run();
  end
endmodule